// File: doc/BRIEF.md
# Processor Interrupt Control Unit

This block sits beside the instruction sequencer of an 8-bit processor core and decides, at each point where control may change hands, what happens next. Another master may ask to own the bus; a non-maskable interrupt may be waiting; a maskable interrupt may be requested. The unit keeps the two interrupt-enable flags and the 2-bit response mode. It also runs the interrupt acknowledge cycle and works out where execution goes next.

The sequencer reports the end of each machine cycle and the last clock of each instruction. The decoder reports enable, disable, return-from-non-maskable and set-mode instructions as one-cycle strobes that coincide with that instruction's last clock. The unit answers with one-cycle take pulses. For a maskable interrupt it drives a stretched acknowledge cycle and then presents a target. The target is a jump address, a table pointer that must be read through, or an opcode byte to execute.

Top module: `irq_ctl_top`

## Requirements
- R1: While `rst` is high at a clock edge, both enable flags clear, the mode returns to 0, the bus is not granted, no acknowledge cycle is running and no take or target pulse is produced.
- R2: A disable strobe clears both enable flags. An enable strobe sets both. A return strobe copies the second flag (`pv_iff`) into the first (`int_en`). All take effect at the clock edge where the strobe is sampled.
- R3: If the last clock of an instruction carries an enable or disable strobe, no interrupt is accepted at that edge. A request that is still pending is accepted at a later instruction end.
- R4: A set-mode strobe selects mode 0, 1 or 2 when `im_op` is 0x46, 0x56 or 0x5E. With any other `im_op` value the mode is unchanged.
- R5: When `bus_req` is high at a machine-cycle end or instruction end and no acknowledge cycle is running, `bus_grant` rises after that edge. It stays high while `bus_req` stays high and drops one cycle after `bus_req` goes low. A bus request at the same edge as an instruction end pre-empts any interrupt. Nothing is accepted while the bus is granted.
- R6: A rising edge on `nmi_in` is remembered until it is served. At the next open instruction end it wins over a maskable request. Its acceptance makes `take_nmi` high for one cycle, together with a target pulse of kind 0 (jump) and address 0x0066. At the same edge the first flag is copied into the second and the first flag is cleared.
- R7: A high `int_req` is accepted at an open instruction end only when the first flag is set (after that edge's instruction strobes) and no non-maskable edge is pending. Acceptance makes `take_int` high for one cycle and clears both flags.
- R8: `ack_iorq` is high for the 4 cycles after an acceptance, the first of which coincides with `take_int`. `ack_wait` is high in the second and third of these cycles. `data_in` is sampled at the edge that ends the fourth cycle, and the target pulse follows in the next cycle.
- R9: The maskable target depends on the mode at capture. Mode 0 gives kind 2 (opcode) with address {0x00, data}. Mode 1 gives kind 0 (jump) with address 0x0038. Mode 2 gives kind 1 (table) with address {`i_reg`, data with bit 0 cleared}. `tgt_kind` and `tgt_addr` hold their last value between pulses.
- R10: `pv_iff` always shows the second enable flag, so that register-to-accumulator moves of the vector and refresh bytes can copy it into the parity/overflow flag.
- R11: An instruction end that arrives while an acknowledge cycle is running is ignored. Requests that are still pending are served at the first instruction end after the cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| nmi_in | input | 1 | Non-maskable request, edge-sensitive, active high |
| int_req | input | 1 | Maskable request, level-sensitive, active high |
| bus_req | input | 1 | External master asks for the bus |
| instr_end | input | 1 | Last clock of the current instruction |
| mcyc_end | input | 1 | Last clock of the current machine cycle |
| ev_ei | input | 1 | Enable-interrupts instruction completing |
| ev_di | input | 1 | Disable-interrupts instruction completing |
| ev_retn | input | 1 | Return-from-non-maskable instruction completing |
| ev_im | input | 1 | Set-mode instruction completing |
| im_op | input | 8 | Second opcode byte of the set-mode instruction |
| i_reg | input | 8 | Interrupt page register |
| data_in | input | 8 | Data bus byte during acknowledge |
| bus_grant | output | 1 | Bus handed to the external master |
| take_nmi | output | 1 | One-cycle pulse: non-maskable interrupt accepted |
| take_int | output | 1 | One-cycle pulse: maskable interrupt accepted |
| ack_iorq | output | 1 | Acknowledge cycle in progress (I/O request instead of memory request) |
| ack_wait | output | 1 | Inserted wait state of the acknowledge cycle |
| tgt_valid | output | 1 | One-cycle pulse: target below is new |
| tgt_kind | output | 2 | 0 jump, 1 table pointer, 2 opcode byte |
| tgt_addr | output | 16 | Target address, pointer or opcode |
| int_en | output | 1 | First enable flag |
| pv_iff | output | 1 | Second enable flag |
| im_mode | output | 2 | Current maskable response mode |

## Verification
The embedded properties check, on every cycle, a set of local rules. The two take pulses never occur together. A granted bus blocks both takes in the following cycle. Each acceptance leaves the flags cleared as required. An enable strobe sets both flags. Wait states appear only inside the acknowledge cycle. A table pointer is always even.

The full story needs the bench's cycle-level reference model. This covers how long a non-maskable edge stays latched across a bus grant or an acknowledge cycle. It covers priority when several requests meet at one edge, the effect of instruction strobes that coincide with a boundary, and which mode's target comes out four cycles after acceptance.

// File: rtl/irq_ctl_pkg.sv
package irq_ctl_pkg;

    typedef enum logic [1:0] {
        TK_JUMP   = 2'd0,
        TK_TABLE  = 2'd1,
        TK_OPCODE = 2'd2
    } tgt_kind_t;

    typedef struct packed {
        logic       valid;
        tgt_kind_t  kind;
        logic [15:0] addr;
    } target_t;

    localparam logic [15:0] NMI_ENTRY  = 16'h0066;
    localparam logic [15:0] MODE1_ENTRY = 16'h0038;
    localparam logic [7:0]  IM_SEL0 = 8'h46;
    localparam logic [7:0]  IM_SEL1 = 8'h56;
    localparam logic [7:0]  IM_SEL2 = 8'h5E;

    // {hit, mode}
    function automatic logic [2:0] im_decode(input logic [7:0] op);
        case (op)
            IM_SEL0: im_decode = {1'b1, 2'd0};
            IM_SEL1: im_decode = {1'b1, 2'd1};
            IM_SEL2: im_decode = {1'b1, 2'd2};
            default: im_decode = 3'b000;
        endcase
    endfunction

    function automatic target_t mask_target(input logic [1:0] mode,
                                            input logic [7:0] page,
                                            input logic [7:0] vec);
        target_t t;
        t.valid = 1'b1;
        case (mode)
            2'd1: begin
                t.kind = TK_JUMP;
                t.addr = MODE1_ENTRY;
            end
            2'd2: begin
                t.kind = TK_TABLE;
                t.addr = {page, vec[7:1], 1'b0};
            end
            default: begin
                t.kind = TK_OPCODE;
                t.addr = {8'h00, vec};
            end
        endcase
        return t;
    endfunction

endpackage

// File: rtl/irq_enable_flags.sv
module irq_enable_flags
    import irq_ctl_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       ev_ei,
    input  logic       ev_di,
    input  logic       ev_retn,
    input  logic       ev_im,
    input  logic [7:0] im_op,
    input  logic       accept_nmi,
    input  logic       accept_int,
    output logic       iff1_eff,
    output logic       iff1,
    output logic       iff2,
    output logic [1:0] mode
);

    logic       nx1, nx2;
    logic [2:0] im_dec;

    // flag values once this edge's instruction strobes are applied
    always_comb begin
        nx1 = iff1;
        nx2 = iff2;
        if (ev_retn) nx1 = iff2;
        if (ev_ei) begin
            nx1 = 1'b1;
            nx2 = 1'b1;
        end
        if (ev_di) begin
            nx1 = 1'b0;
            nx2 = 1'b0;
        end
        im_dec   = im_decode(im_op);
        iff1_eff = nx1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            iff1 <= 1'b0;
            iff2 <= 1'b0;
            mode <= 2'd0;
        end else begin
            if (accept_nmi) begin
                iff2 <= nx1;
                iff1 <= 1'b0;
            end else if (accept_int) begin
                iff1 <= 1'b0;
                iff2 <= 1'b0;
            end else begin
                iff1 <= nx1;
                iff2 <= nx2;
            end
            if (ev_im && im_dec[2]) mode <= im_dec[1:0];
        end
    end

    p_nmi_clears_r6: assert property (@(posedge clk) disable iff (rst)
        accept_nmi |=> !iff1);
    p_int_clears_r7: assert property (@(posedge clk) disable iff (rst)
        accept_int |=> (!iff1 && !iff2));
    p_ei_sets_r2: assert property (@(posedge clk) disable iff (rst)
        (ev_ei && !ev_di) |=> (iff1 && iff2));

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter (
    input  logic clk,
    input  logic rst,
    input  logic nmi_in,
    input  logic int_req,
    input  logic bus_req,
    input  logic instr_end,
    input  logic mcyc_end,
    input  logic ev_ei,
    input  logic ev_di,
    input  logic ack_busy,
    input  logic iff1_eff,
    output logic accept_nmi,
    output logic accept_int,
    output logic bus_grant,
    output logic take_nmi,
    output logic take_int
);

    logic nmi_prev, nmi_pend, nmi_seen;
    logic bus_take, open_slot;

    always_comb begin
        nmi_seen  = nmi_pend | (nmi_in & ~nmi_prev);
        bus_take  = bus_req & ~bus_grant & ~ack_busy & (mcyc_end | instr_end);
        open_slot = instr_end & ~bus_grant & ~ack_busy & ~bus_req
                    & ~ev_ei & ~ev_di;
        accept_nmi = open_slot & nmi_seen;
        accept_int = open_slot & ~nmi_seen & int_req & iff1_eff;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            nmi_prev  <= 1'b0;
            nmi_pend  <= 1'b0;
            bus_grant <= 1'b0;
            take_nmi  <= 1'b0;
            take_int  <= 1'b0;
        end else begin
            nmi_prev  <= nmi_in;
            nmi_pend  <= nmi_seen & ~accept_nmi;
            bus_grant <= bus_take | (bus_grant & bus_req);
            take_nmi  <= accept_nmi;
            take_int  <= accept_int;
        end
    end

    p_one_take_r7: assert property (@(posedge clk) disable iff (rst)
        !(take_nmi && take_int));
    p_grant_blocks_r5: assert property (@(posedge clk) disable iff (rst)
        bus_grant |=> (!take_nmi && !take_int));
    p_grant_holds_r5: assert property (@(posedge clk) disable iff (rst)
        (bus_grant && bus_req) |=> bus_grant);

endmodule

// File: rtl/irq_ack_seq.sv
module irq_ack_seq
    import irq_ctl_pkg::*;
#(
    parameter int BASE_CYCLES = 2,
    parameter int WAIT_STATES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic       nmi_load,
    input  logic [1:0] mode,
    input  logic [7:0] page,
    input  logic [7:0] data_in,
    output logic       busy,
    output logic       ack_iorq,
    output logic       ack_wait,
    output target_t    tgt
);

    localparam int ACK_CYCLES = BASE_CYCLES + WAIT_STATES;
    localparam int CW = (ACK_CYCLES > 2) ? $clog2(ACK_CYCLES) : 1;
    localparam logic [CW-1:0] LAST  = CW'(ACK_CYCLES - 1);
    localparam logic [CW-1:0] WLAST = CW'(WAIT_STATES);

    logic [CW-1:0] cnt;

    always_comb begin
        ack_iorq = busy;
        ack_wait = busy && (cnt != '0) && (cnt <= WLAST);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            cnt  <= '0;
            tgt  <= '0;
        end else begin
            tgt.valid <= 1'b0;
            if (start) begin
                busy <= 1'b1;
                cnt  <= '0;
            end else if (busy) begin
                if (cnt == LAST) begin
                    busy <= 1'b0;
                    tgt  <= mask_target(mode, page, data_in);
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
            if (nmi_load) begin
                tgt.valid <= 1'b1;
                tgt.kind  <= TK_JUMP;
                tgt.addr  <= NMI_ENTRY;
            end
        end
    end

    p_wait_inside_r8: assert property (@(posedge clk) disable iff (rst)
        ack_wait |-> ack_iorq);
    p_target_after_ack_r8: assert property (@(posedge clk) disable iff (rst)
        $fell(ack_iorq) |-> tgt.valid);
    p_table_even_r9: assert property (@(posedge clk) disable iff (rst)
        (tgt.valid && tgt.kind == TK_TABLE) |-> !tgt.addr[0]);

endmodule

// File: rtl/irq_ctl_top.sv
module irq_ctl_top
    import irq_ctl_pkg::*;
#(
    parameter int BASE_CYCLES = 2,
    parameter int WAIT_STATES = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        nmi_in,
    input  logic        int_req,
    input  logic        bus_req,
    input  logic        instr_end,
    input  logic        mcyc_end,
    input  logic        ev_ei,
    input  logic        ev_di,
    input  logic        ev_retn,
    input  logic        ev_im,
    input  logic [7:0]  im_op,
    input  logic [7:0]  i_reg,
    input  logic [7:0]  data_in,
    output logic        bus_grant,
    output logic        take_nmi,
    output logic        take_int,
    output logic        ack_iorq,
    output logic        ack_wait,
    output logic        tgt_valid,
    output logic [1:0]  tgt_kind,
    output logic [15:0] tgt_addr,
    output logic        int_en,
    output logic        pv_iff,
    output logic [1:0]  im_mode
);

    logic    accept_nmi, accept_int, iff1_eff, ack_busy;
    target_t tgt;

    irq_enable_flags u_flags (
        .clk        (clk),
        .rst        (rst),
        .ev_ei      (ev_ei),
        .ev_di      (ev_di),
        .ev_retn    (ev_retn),
        .ev_im      (ev_im),
        .im_op      (im_op),
        .accept_nmi (accept_nmi),
        .accept_int (accept_int),
        .iff1_eff   (iff1_eff),
        .iff1       (int_en),
        .iff2       (pv_iff),
        .mode       (im_mode)
    );

    irq_arbiter u_arb (
        .clk        (clk),
        .rst        (rst),
        .nmi_in     (nmi_in),
        .int_req    (int_req),
        .bus_req    (bus_req),
        .instr_end  (instr_end),
        .mcyc_end   (mcyc_end),
        .ev_ei      (ev_ei),
        .ev_di      (ev_di),
        .ack_busy   (ack_busy),
        .iff1_eff   (iff1_eff),
        .accept_nmi (accept_nmi),
        .accept_int (accept_int),
        .bus_grant  (bus_grant),
        .take_nmi   (take_nmi),
        .take_int   (take_int)
    );

    irq_ack_seq #(
        .BASE_CYCLES (BASE_CYCLES),
        .WAIT_STATES (WAIT_STATES)
    ) u_ack (
        .clk      (clk),
        .rst      (rst),
        .start    (accept_int),
        .nmi_load (accept_nmi),
        .mode     (im_mode),
        .page     (i_reg),
        .data_in  (data_in),
        .busy     (ack_busy),
        .ack_iorq (ack_iorq),
        .ack_wait (ack_wait),
        .tgt      (tgt)
    );

    always_comb begin
        tgt_valid = tgt.valid;
        tgt_kind  = tgt.kind;
        tgt_addr  = tgt.addr;
    end

    p_ack_follows_take_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(ack_iorq) |-> take_int);

endmodule

// File: tb/test_irq_ctl_top.sv
module test_irq_ctl_top;

    localparam int ACK_LEN  = 4;
    localparam int WAIT_LEN = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic nmi_in = 0, int_req = 0, bus_req = 0, instr_end = 0, mcyc_end = 0;
    logic ev_ei = 0, ev_di = 0, ev_retn = 0, ev_im = 0;
    logic [7:0] im_op = 0, i_reg = 0, data_in = 0;
    logic bus_grant, take_nmi, take_int, ack_iorq, ack_wait, tgt_valid;
    logic [1:0] tgt_kind, im_mode;
    logic [15:0] tgt_addr;
    logic int_en, pv_iff;

    int vectors = 0;
    int fails = 0;

    always #2.5 clk = ~clk;

    irq_ctl_top i_irq_ctl_top (
        .clk(clk), .rst(rst), .nmi_in(nmi_in), .int_req(int_req),
        .bus_req(bus_req), .instr_end(instr_end), .mcyc_end(mcyc_end),
        .ev_ei(ev_ei), .ev_di(ev_di), .ev_retn(ev_retn), .ev_im(ev_im),
        .im_op(im_op), .i_reg(i_reg), .data_in(data_in),
        .bus_grant(bus_grant), .take_nmi(take_nmi), .take_int(take_int),
        .ack_iorq(ack_iorq), .ack_wait(ack_wait), .tgt_valid(tgt_valid),
        .tgt_kind(tgt_kind), .tgt_addr(tgt_addr), .int_en(int_en),
        .pv_iff(pv_iff), .im_mode(im_mode)
    );

    task automatic chk(input string tag, input int act, input int exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    bit m_ok = 0;
    int m_grant, m_tn, m_ti, m_i1, m_i2, m_mode, m_prev, m_pend;
    int m_cnt, m_tv, m_kind, m_addr;

    always @(posedge clk) begin : model
        int n1, n2;
        bit pend_now, busy0, open_slot, tn, ti;
        if (rst) begin
            m_grant = 0; m_tn = 0; m_ti = 0; m_i1 = 0; m_i2 = 0; m_mode = 0;
            m_prev = 0; m_pend = 0; m_cnt = -1; m_tv = 0; m_kind = 0; m_addr = 0;
            m_ok = 1;
        end else begin
            busy0    = (m_cnt >= 0);
            pend_now = (m_pend != 0) || (nmi_in && m_prev == 0);
            n1 = m_i1; n2 = m_i2;
            if (ev_retn) n1 = m_i2;
            if (ev_ei) begin n1 = 1; n2 = 1; end
            if (ev_di) begin n1 = 0; n2 = 0; end
            open_slot = instr_end && m_grant == 0 && !busy0 && !bus_req && !ev_ei && !ev_di;
            tn = open_slot && pend_now;
            ti = open_slot && !pend_now && int_req && n1 == 1;
            m_tv = 0;
            if (busy0) begin
                if (m_cnt == ACK_LEN - 1) begin
                    m_cnt = -1;
                    m_tv = 1;
                    if (m_mode == 1) begin m_kind = 0; m_addr = 16'h0038; end
                    else if (m_mode == 2) begin m_kind = 1; m_addr = {i_reg, data_in[7:1], 1'b0}; end
                    else begin m_kind = 2; m_addr = {8'h00, data_in}; end
                end else m_cnt++;
            end
            if (m_grant == 0) m_grant = (bus_req && !busy0 && (mcyc_end || instr_end)) ? 1 : 0;
            else m_grant = bus_req ? 1 : 0;
            if (tn) begin
                n2 = n1; n1 = 0; m_pend = 0;
                m_tv = 1; m_kind = 0; m_addr = 16'h0066;
            end else m_pend = pend_now;
            if (ti) begin n1 = 0; n2 = 0; m_cnt = 0; end
            m_i1 = n1; m_i2 = n2; m_tn = tn; m_ti = ti; m_prev = nmi_in;
            if (ev_im) begin
                if (im_op == 8'h46) m_mode = 0;
                else if (im_op == 8'h56) m_mode = 1;
                else if (im_op == 8'h5E) m_mode = 2;
            end
        end
    end

    always @(negedge clk) begin
        if (m_ok) begin
            chk("R5 bus_grant", bus_grant, m_grant);
            chk("R6 take_nmi", take_nmi, m_tn);
            chk("R7 take_int", take_int, m_ti);
            chk("R8 ack_iorq", ack_iorq, m_cnt >= 0);
            chk("R8 ack_wait", ack_wait, m_cnt >= 1 && m_cnt <= WAIT_LEN);
            chk("R9 tgt_valid", tgt_valid, m_tv);
            chk("R9 tgt_kind", tgt_kind, m_kind);
            chk("R9 tgt_addr", tgt_addr, m_addr);
            chk("R2 int_en", int_en, m_i1);
            chk("R10 pv_iff", pv_iff, m_i2);
            chk("R4 im_mode", im_mode, m_mode);
        end
    end

    // ---------------- stimulus ----------------
    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic boundary();
        instr_end = 1; tick(); instr_end = 0;
    endtask

    task automatic ei_boundary();
        ev_ei = 1; instr_end = 1; tick(); ev_ei = 0; instr_end = 0;
    endtask

    task automatic set_mode(input logic [7:0] op);
        ev_im = 1; im_op = op; tick(); ev_im = 0;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (3) tick();
        rst = 0;
        // R1 reset state
        chk("R1 int_en", int_en, 0);
        chk("R1 pv_iff", pv_iff, 0);
        chk("R1 im_mode", im_mode, 0);
        chk("R1 bus_grant", bus_grant, 0);
        chk("R1 ack_iorq", ack_iorq, 0);
        chk("R1 tgt_valid", tgt_valid, 0);

        // R7 masked when disabled
        int_req = 1; boundary();
        chk("R7 masked", take_int, 0);

        // R3 enable boundary does not sample
        ei_boundary();
        chk("R3 no take at EI", take_int, 0);
        chk("R2 EI int_en", int_en, 1);

        // mode 0 acknowledge
        data_in = 8'hFF;
        boundary();
        int_req = 0;
        chk("R7 take", take_int, 1);
        chk("R7 cleared", int_en, 0);
        chk("R8 iorq first", ack_iorq, 1);
        tick(); chk("R8 wait", ack_wait, 1);
        tick(); tick(); chk("R8 no wait last", ack_wait, 0);
        tick();
        chk("R9 m0 valid", tgt_valid, 1);
        chk("R9 m0 kind", tgt_kind, 2);
        chk("R9 m0 addr", tgt_addr, 16'h00FF);

        // R4 mode select and ignored byte
        set_mode(8'h56); chk("R4 mode1", im_mode, 1);
        set_mode(8'h4E); chk("R4 ignored", im_mode, 1);

        // mode 1
        ei_boundary();
        int_req = 1; boundary(); int_req = 0;
        repeat (ACK_LEN) tick();
        chk("R9 m1 kind", tgt_kind, 0);
        chk("R9 m1 addr", tgt_addr, 16'h0038);

        // mode 2
        set_mode(8'h5E);
        i_reg = 8'h3A; data_in = 8'h57;
        ei_boundary();
        int_req = 1; boundary(); int_req = 0;
        repeat (ACK_LEN) tick();
        chk("R9 m2 kind", tgt_kind, 1);
        chk("R9 m2 addr", tgt_addr, 16'h3A56);

        // R6 latched short pulse
        ei_boundary();
        nmi_in = 1; tick(); nmi_in = 0; tick(); tick();
        boundary();
        chk("R6 take", take_nmi, 1);
        chk("R6 addr", tgt_addr, 16'h0066);
        chk("R6 iff1", int_en, 0);
        chk("R10 saved", pv_iff, 1);
        ev_retn = 1; boundary(); ev_retn = 0;
        chk("R2 restore", int_en, 1);

        // R6 priority over maskable
        nmi_in = 1; int_req = 1; boundary(); nmi_in = 0; int_req = 0;
        chk("R6 wins", take_nmi, 1);
        chk("R6 int loses", take_int, 0);
        ev_retn = 1; boundary(); ev_retn = 0;

        // R5 grant blocks, NMI stays latched
        bus_req = 1; mcyc_end = 1; tick(); mcyc_end = 0;
        chk("R5 grant", bus_grant, 1);
        int_req = 1; nmi_in = 1; boundary(); nmi_in = 0;
        chk("R5 blocked nmi", take_nmi, 0);
        chk("R5 blocked int", take_int, 0);
        bus_req = 0; tick();
        chk("R5 release", bus_grant, 0);
        boundary();
        chk("R6 after grant", take_nmi, 1);
        int_req = 0;

        // R5 bus request at instruction end pre-empts
        ev_retn = 1; boundary(); ev_retn = 0;
        int_req = 1; bus_req = 1; boundary();
        chk("R5 preempt grant", bus_grant, 1);
        chk("R5 preempt int", take_int, 0);
        bus_req = 0; tick();
        boundary();
        chk("R7 after release", take_int, 1);
        int_req = 0;

        // R11 boundary during acknowledge
        nmi_in = 1; boundary(); nmi_in = 0;
        chk("R11 ignored", take_nmi, 0);
        repeat (ACK_LEN - 1) tick();
        boundary();
        chk("R11 served", take_nmi, 1);

        // R2 disable
        ei_boundary();
        ev_di = 1; instr_end = 1; tick(); ev_di = 0; instr_end = 0;
        chk("R2 DI", int_en, 0);
        chk("R10 DI", pv_iff, 0);

        repeat (2) tick();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule